// File: doc/BRIEF.md
# Directory-Coherent Cache Line Controller

This block is the coherence engine on the cache side of one node in a multiprocessor whose caches are kept consistent by a home directory rather than by a shared bus. It holds a small direct-mapped array of lines. Each line is Invalid, Shared (readable, memory up to date) or Exclusive (sole copy, writable, dirty). When the processor misses, the block sends a point-to-point request to the home of the block and holds the processor stalled until the home answers with a data reply.

In the other direction, the home sends commands. An invalidate removes a shared copy. A fetch pulls the dirty data back and leaves the line readable. A fetch-and-invalidate pulls the data back and drops the line. When a dirty line must make room for another block, the block first writes the old data back to its home. All traffic is carried by two valid/ready message ports. Each message holds a 3-bit kind, the 4-bit sender node, a block address and one data word. Kind codes: 0 read request, 1 write request, 2 invalidate, 3 fetch, 4 fetch-and-invalidate, 5 data reply, 6 data write-back.

Top module: `dircache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `out_valid` and `cpu_done` are 0, and `in_ready` is 1.
- R2: A read to a line that is not valid for that address sends a kind-0 message carrying this node's ID and the address. On the kind-5 reply, the reply data is returned with a one-cycle `cpu_done`, and the line becomes Shared.
- R3: A read to a Shared or Exclusive line holding that address completes with the stored word and sends no message.
- R4: A write to a line that is not Exclusive for that address, including a Shared one, sends a kind-1 message. After the reply, the line is Exclusive and holds the written word, not the reply word.
- R5: A write to an Exclusive line holding that address updates the word and completes with no message.
- R6: A kind-2 message whose address matches a valid line makes that line Invalid, so the next read of it misses.
- R7: A kind-3 message that matches an Exclusive line sends a kind-6 message with that address and word, and the line becomes Shared: reads hit, and a write sends kind 1.
- R8: A kind-4 message that matches a valid line makes it Invalid. If the line was Exclusive, a kind-6 message with its address and word is sent.
- R9: A miss whose line index holds an Exclusive line of another address first sends a kind-6 message with the old address and word, then the request. A Shared line being replaced is dropped with no message.
- R10: An incoming command that matches no valid line, or a fetch that matches a line that is not Exclusive, is accepted and changes nothing: no message is sent, and the line still hits.
- R11: While waiting for its reply, the processor sees no `cpu_done`, and incoming commands for other lines are still accepted and acted on.
- R12: While `out_valid` is 1 and `out_ready` is 0, the outgoing message stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request, held until `cpu_done` |
| cpu_req_write | input | 1 | 1 for write, 0 for read |
| cpu_req_addr | input | 8 | Block address of request |
| cpu_req_wdata | input | 16 | Word to write |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read word (or written word on a write) |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Network accepts outgoing message |
| out_type | output | 3 | Outgoing message kind |
| out_node | output | 4 | Sender node ID |
| out_addr | output | 8 | Outgoing block address |
| out_data | output | 16 | Outgoing data word |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Block accepts incoming message |
| in_type | input | 3 | Incoming message kind |
| in_addr | input | 8 | Incoming block address |
| in_data | input | 16 | Incoming data word |

## Verification
The hardest situation to reach is a home command arriving while the processor is stalled on its own miss. The controller must accept and act on the command without finishing the stalled access. The stimulus issues a read miss and holds back the reply. While the processor is stalled, it sends an invalidate for a different shared line. It then checks that `cpu_done` stays low and that a later read of the invalidated line misses. Fetch commands are reached by first installing a line Exclusive through a write miss, and back-pressure is reached by withholding `out_ready` on a pending request.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;
    parameter int ADDR_W = 8;
    parameter int DATA_W = 16;
    parameter int NODE_W = 4;
    parameter int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        M_RDREQ   = 3'd0,
        M_WRREQ   = 3'd1,
        M_INV     = 3'd2,
        M_FETCH   = 3'd3,
        M_FETCHIV = 3'd4,
        M_REPLY   = 3'd5,
        M_WBACK   = 3'd6
    } msg_e;

    typedef enum logic [1:0] {
        L_INV = 2'd0,
        L_SHR = 2'd1,
        L_EXC = 2'd2
    } lst_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MISS = 2'd1,
        S_WAIT = 2'd2,
        S_DONE = 2'd3
    } ctl_e;

    typedef struct packed {
        lst_e              st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        msg_e              kind;
        logic [NODE_W-1:0] node;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } msg_t;

    function automatic logic line_holds(line_t l, logic [ADDR_W-1:0] a);
        return (l.st != L_INV) && (l.addr == a);
    endfunction
endpackage

// File: rtl/dc_line_store.sv
`timescale 1ns/1ps
module dc_line_store
    import coh_pkg::*;
#(
    parameter int LINES = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] a_idx,
    output line_t            a_line,
    input  logic [IDX_W-1:0] b_idx,
    output line_t            b_line,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  line_t            w_line
);
    line_t lines_q [LINES];

    assign a_line = lines_q[a_idx];
    assign b_line = lines_q[b_idx];

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) begin
                    lines_q[g].st <= L_INV;
                end else if (we && (w_idx == IDX_W'(g))) begin
                    lines_q[g] <= w_line;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dc_cmd_eval.sv
`timescale 1ns/1ps
module dc_cmd_eval
    import coh_pkg::*;
(
    input  msg_e              kind,
    input  logic [ADDR_W-1:0] addr,
    input  line_t             cur,
    output logic              match,
    output logic              upd,
    output logic              send_blk,
    output line_t             nxt
);
    always_comb begin
        match    = line_holds(cur, addr);
        upd      = 1'b0;
        send_blk = 1'b0;
        nxt      = cur;
        case (kind)
            M_INV: begin
                if (match) begin
                    upd    = 1'b1;
                    nxt.st = L_INV;
                end
            end
            M_FETCH: begin
                if (match && cur.st == L_EXC) begin
                    upd      = 1'b1;
                    send_blk = 1'b1;
                    nxt.st   = L_SHR;
                end
            end
            M_FETCHIV: begin
                if (match) begin
                    upd      = 1'b1;
                    send_blk = (cur.st == L_EXC);
                    nxt.st   = L_INV;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dircache_ctrl.sv
`timescale 1ns/1ps
module dircache_ctrl
    import coh_pkg::*;
#(
    parameter logic [NODE_W-1:0] NODE_ID = 4'd3,
    parameter int LINES = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [KIND_W-1:0] out_type,
    output logic [NODE_W-1:0] out_node,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [KIND_W-1:0] in_type,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data
);
    ctl_e              state, nstate;
    msg_t              out_q, out_nxt;
    logic              out_v, load_out;
    logic [DATA_W-1:0] rdata_q, rdata_nxt;
    logic              set_rdata;
    line_t             cpu_line, in_line, w_line, ev_nxt;
    logic              we;
    logic [IDX_W-1:0]  w_idx;
    logic              ev_match, ev_upd, ev_send;
    msg_e              in_kind;
    logic              in_fire, cpu_hit, victim_dirty;
    msg_t              req_msg;

    assign in_kind = msg_e'(in_type);

    dc_line_store #(.LINES(LINES)) u_store (
        .clk(clk), .rst(rst),
        .a_idx(cpu_req_addr[IDX_W-1:0]), .a_line(cpu_line),
        .b_idx(in_addr[IDX_W-1:0]),      .b_line(in_line),
        .we(we), .w_idx(w_idx), .w_line(w_line)
    );

    dc_cmd_eval u_eval (
        .kind(in_kind), .addr(in_addr), .cur(in_line),
        .match(ev_match), .upd(ev_upd), .send_blk(ev_send), .nxt(ev_nxt)
    );

    assign in_ready = ((state == S_IDLE) || (state == S_WAIT)) && !out_v;
    assign in_fire  = in_valid && in_ready;

    assign cpu_hit = cpu_req_write
        ? (cpu_line.st == L_EXC && cpu_line.addr == cpu_req_addr)
        : line_holds(cpu_line, cpu_req_addr);
    assign victim_dirty = (cpu_line.st == L_EXC) && (cpu_line.addr != cpu_req_addr);

    always_comb begin
        req_msg.kind = cpu_req_write ? M_WRREQ : M_RDREQ;
        req_msg.node = NODE_ID;
        req_msg.addr = cpu_req_addr;
        req_msg.data = cpu_req_write ? cpu_req_wdata : '0;
    end

    always_comb begin
        nstate    = state;
        we        = 1'b0;
        w_idx     = cpu_req_addr[IDX_W-1:0];
        w_line    = cpu_line;
        load_out  = 1'b0;
        out_nxt   = req_msg;
        set_rdata = 1'b0;
        rdata_nxt = rdata_q;
        case (state)
            S_IDLE, S_WAIT: begin
                if (in_fire && in_kind == M_REPLY) begin
                    if (state == S_WAIT) begin
                        we          = 1'b1;
                        w_line.st   = cpu_req_write ? L_EXC : L_SHR;
                        w_line.addr = cpu_req_addr;
                        w_line.data = cpu_req_write ? cpu_req_wdata : in_data;
                        set_rdata   = 1'b1;
                        rdata_nxt   = w_line.data;
                        nstate      = S_DONE;
                    end
                end else if (in_fire) begin
                    we     = ev_upd;
                    w_idx  = in_addr[IDX_W-1:0];
                    w_line = ev_nxt;
                    if (ev_send) begin
                        load_out = 1'b1;
                        out_nxt  = '{kind: M_WBACK, node: NODE_ID,
                                     addr: in_line.addr, data: in_line.data};
                    end
                end else if (state == S_IDLE && cpu_req_valid && !out_v) begin
                    if (cpu_hit) begin
                        if (cpu_req_write) begin
                            we          = 1'b1;
                            w_line.data = cpu_req_wdata;
                        end
                        set_rdata = 1'b1;
                        rdata_nxt = cpu_req_write ? cpu_req_wdata : cpu_line.data;
                        nstate    = S_DONE;
                    end else if (victim_dirty) begin
                        load_out  = 1'b1;
                        out_nxt   = '{kind: M_WBACK, node: NODE_ID,
                                      addr: cpu_line.addr, data: cpu_line.data};
                        we        = 1'b1;
                        w_line.st = L_INV;
                        nstate    = S_MISS;
                    end else begin
                        load_out = 1'b1;
                        nstate   = S_WAIT;
                    end
                end
            end
            S_MISS: begin
                if (!out_v) begin
                    load_out = 1'b1;
                    nstate   = S_WAIT;
                end
            end
            default: nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            out_v   <= 1'b0;
            out_q   <= '{kind: M_RDREQ, node: '0, addr: '0, data: '0};
            rdata_q <= '0;
        end else begin
            state <= nstate;
            if (load_out) begin
                out_q <= out_nxt;
                out_v <= 1'b1;
            end else if (out_v && out_ready) begin
                out_v <= 1'b0;
            end
            if (set_rdata) rdata_q <= rdata_nxt;
        end
    end

    assign cpu_done  = (state == S_DONE);
    assign cpu_rdata = rdata_q;
    assign out_valid = out_v;
    assign out_type  = out_q.kind;
    assign out_node  = out_q.node;
    assign out_addr  = out_q.addr;
    assign out_data  = out_q.data;

    p_out_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_type)
            && $stable(out_addr) && $stable(out_data)));

    p_reply_done_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && in_fire && in_kind == M_REPLY) |=> cpu_done);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    p_fetch_sends_r7: assert property (@(posedge clk) disable iff (rst)
        (in_fire && in_kind == M_FETCH && ev_send) |=>
            (out_valid && out_type == M_WBACK && out_addr == $past(in_addr)));

    p_inv_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (in_fire && in_kind == M_INV) |=> !out_valid);

    p_stall_r11: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && !(in_fire && in_kind == M_REPLY)) |=> !cpu_done);
endmodule

// File: tb/dircache_ctrl_test.sv
`timescale 1ns/1ps
module dircache_ctrl_test;
    localparam logic [3:0] NODE = 4'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [7:0]  cpu_req_addr = '0;
    logic [15:0] cpu_req_wdata = '0;
    logic        cpu_done;
    logic [15:0] cpu_rdata;
    logic        out_valid, out_ready = 1'b0;
    logic [2:0]  out_type;
    logic [3:0]  out_node;
    logic [7:0]  out_addr;
    logic [15:0] out_data;
    logic        in_valid = 1'b0, in_ready;
    logic [2:0]  in_type = '0;
    logic [7:0]  in_addr = '0;
    logic [15:0] in_data = '0;

    int total = 0;
    int fails = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dircache_ctrl #(.NODE_ID(NODE), .LINES(4)) uut (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
        .out_node(out_node), .out_addr(out_addr), .out_data(out_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
        .in_addr(in_addr), .in_data(in_data)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [15:0] wdata;
        logic [1:0]  kind;     // 0 hit, 1 read request, 2 write request
        logic        wb;
        logic [7:0]  wb_addr;
        logic [15:0] wb_data;
        logic [15:0] rep;
        logic [15:0] expv;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 8'h10, 16'h0000, 2'd1, 1'b0, 8'h00, 16'h0000, 16'h1111, 16'h1111},
        '{1'b0, 8'h10, 16'h0000, 2'd0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h1111},
        '{1'b1, 8'h10, 16'hA0A0, 2'd2, 1'b0, 8'h00, 16'h0000, 16'h1111, 16'hA0A0},
        '{1'b0, 8'h10, 16'h0000, 2'd0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'hA0A0},
        '{1'b1, 8'h10, 16'hB0B0, 2'd0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'hB0B0},
        '{1'b0, 8'h14, 16'h0000, 2'd1, 1'b1, 8'h10, 16'hB0B0, 16'h2222, 16'h2222},
        '{1'b0, 8'h14, 16'h0000, 2'd0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h2222},
        '{1'b1, 8'h21, 16'h3333, 2'd2, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h3333},
        '{1'b0, 8'h25, 16'h0000, 2'd1, 1'b1, 8'h21, 16'h3333, 16'h4444, 16'h4444},
        '{1'b0, 8'h18, 16'h0000, 2'd1, 1'b0, 8'h00, 16'h0000, 16'h5555, 16'h5555}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic start_req(input logic wr, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
    endtask

    task automatic take_msg(input string req, input logic [2:0] k, input logic [7:0] a,
                            input logic chk_data, input logic [15:0] d);
        int n = 0;
        while (!out_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'd0, out_valid}, 32'd1);
        chk(req, {29'd0, out_type}, {29'd0, k});
        chk(req, {24'd0, out_addr}, {24'd0, a});
        chk(req, {28'd0, out_node}, {28'd0, NODE});
        if (chk_data) chk(req, {16'd0, out_data}, {16'd0, d});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic send_in(input logic [2:0] k, input logic [7:0] a, input logic [15:0] d);
        int n = 0;
        in_valid = 1'b1;
        in_type  = k;
        in_addr  = a;
        in_data  = d;
        while (!in_ready && n < 60) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_done(input string req, input logic [15:0] expv);
        int n = 0;
        while (!cpu_done && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'd0, cpu_done}, 32'd1);
        chk(req, {16'd0, cpu_rdata}, {16'd0, expv});
        cpu_req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic quiet(input string req, input int n);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
        end
        chk(req, {31'd0, seen}, 32'd0);
    endtask

    task automatic do_hit(input string req, input logic wr, input logic [7:0] a,
                          input logic [15:0] d, input logic [15:0] expv);
        start_req(wr, a, d);
        wait_done(req, expv);
        chk(req, {31'd0, out_valid}, 32'd0);
    endtask

    task automatic do_miss(input string req, input logic wr, input logic [7:0] a,
                           input logic [15:0] d, input logic [15:0] rep, input logic [15:0] expv);
        start_req(wr, a, d);
        take_msg(req, wr ? 3'd1 : 3'd0, a, 1'b0, 16'h0);
        send_in(3'd5, a, rep);
        wait_done(req, expv);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                fails++;
                total++;
                $display("FAIL watchdog actual=%0d expected<50000", cycles);
                $display("%0d/%0d checks passed", total - fails, total);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", {31'd0, out_valid}, 32'd0);
        chk("R1", {31'd0, cpu_done}, 32'd0);
        chk("R1", {31'd0, in_ready}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            string tag;
            if (TBL[i].wb) tag = "R9";
            else if (TBL[i].kind == 2'd0) tag = TBL[i].wr ? "R5" : "R3";
            else if (TBL[i].kind == 2'd1) tag = "R2";
            else tag = "R4";
            start_req(TBL[i].wr, TBL[i].addr, TBL[i].wdata);
            if (TBL[i].wb) take_msg(tag, 3'd6, TBL[i].wb_addr, 1'b1, TBL[i].wb_data);
            if (TBL[i].kind != 2'd0) begin
                take_msg(tag, (TBL[i].kind == 2'd2) ? 3'd1 : 3'd0, TBL[i].addr, 1'b0, 16'h0);
                send_in(3'd5, TBL[i].addr, TBL[i].rep);
                wait_done(tag, TBL[i].expv);
            end else begin
                wait_done(tag, TBL[i].expv);
                chk(tag, {31'd0, out_valid}, 32'd0);
            end
        end

        // R10: unmatched invalidate and fetch of a non-exclusive line change nothing
        send_in(3'd2, 8'h1C, 16'h0);
        quiet("R10", 4);
        do_hit("R10", 1'b0, 8'h18, 16'h0, 16'h5555);
        send_in(3'd3, 8'h25, 16'h0);
        quiet("R10", 4);
        do_hit("R10", 1'b0, 8'h25, 16'h0, 16'h4444);

        // R6: invalidate of a shared line forces the next read to miss
        send_in(3'd2, 8'h18, 16'h0);
        quiet("R6", 3);
        do_miss("R6", 1'b0, 8'h18, 16'h0, 16'h6666, 16'h6666);

        // R7: fetch of an exclusive line returns data, line becomes shared
        do_miss("R7", 1'b1, 8'h32, 16'h7777, 16'h0000, 16'h7777);
        send_in(3'd3, 8'h32, 16'h0);
        take_msg("R7", 3'd6, 8'h32, 1'b1, 16'h7777);
        do_hit("R7", 1'b0, 8'h32, 16'h0, 16'h7777);
        do_miss("R7", 1'b1, 8'h32, 16'h8888, 16'h0101, 16'h8888);

        // R8: fetch-and-invalidate returns data and drops the line
        send_in(3'd4, 8'h32, 16'h0);
        take_msg("R8", 3'd6, 8'h32, 1'b1, 16'h8888);
        do_miss("R8", 1'b0, 8'h32, 16'h0, 16'h1234, 16'h1234);

        // R11: stalled processor, home command for another line serviced meanwhile
        start_req(1'b0, 8'h03, 16'h0);
        take_msg("R11", 3'd0, 8'h03, 1'b0, 16'h0);
        begin
            logic early = 1'b0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (cpu_done) early = 1'b1;
            end
            chk("R11", {31'd0, early}, 32'd0);
        end
        send_in(3'd2, 8'h25, 16'h0);
        chk("R11", {31'd0, cpu_done}, 32'd0);
        send_in(3'd5, 8'h03, 16'h9999);
        wait_done("R11", 16'h9999);
        do_miss("R11", 1'b0, 8'h25, 16'h0, 16'h4545, 16'h4545);

        // R12: outgoing request held stable under back-pressure
        start_req(1'b0, 8'h2E, 16'h0);
        begin
            int n = 0;
            logic moved = 1'b0;
            while (!out_valid && n < 20) begin
                @(negedge clk);
                n++;
            end
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (!out_valid || out_type !== 3'd0 || out_addr !== 8'h2E) moved = 1'b1;
            end
            chk("R12", {31'd0, moved}, 32'd0);
        end
        take_msg("R12", 3'd0, 8'h2E, 1'b0, 16'h0);
        send_in(3'd5, 8'h2E, 16'hCAFE);
        wait_done("R12", 16'hCAFE);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule